// File: doc/BRIEF.md
# Multi-Mode Timer/Counter Unit

This block is a programmable timer/counter built from two byte-wide count registers, a low byte and a high byte. Each step comes from one of two sources. In timer mode it is a machine cycle, which is a fixed number of input clocks. In counter mode it is a rising edge seen on an external event pin. The two bytes can be arranged in four ways: one wide 16-bit counter, two separate byte counters, a byte counter behind a 5-bit prescaler, or a byte counter that reloads from the high byte whenever it wraps.

Each wrap raises a sticky overflow flag. The flag can serve as an interrupt request, or software can poll it and clear it with a strobe. The block also emits a one-clock overflow pulse that a neighbouring bit-rate generator can use as its tick. In the split mode the high byte always counts machine cycles and has a flag and a clear of its own. Both count bytes can be read at any time and written from outside.

Top module: `tmr_unit`

## Requirements
- R1: Out of reset both count bytes and both flags read 0. With runEn high and countSel 0, the count advances by exactly one every 12 clocks: any 12N consecutive clocks that contain no write add N.
- R2: With countSel 1, the count advances once for each 0-to-1 change of eventIn. eventIn passes through two synchronizing flops and is then sampled once per machine cycle, so a level that is held for at least two machine cycles is counted exactly once. A level held high does not advance the count again.
- R3: modeSel 0 (wide mode): the high and low bytes form a single 16-bit count with the high byte as the upper half. The step after 16'hFFFF gives 0 and sets ovfFlag.
- R4: modeSel 1 (split mode): the low byte counts the selected steps and wraps from 8'hFF to 0, setting ovfFlag. The high byte counts machine cycles whatever countSel is, and its wrap from 8'hFF to 0 sets auxFlag. auxClr clears auxFlag.
- R5: modeSel 2 (prescaled mode): low bits [4:0] count the steps. When they are 31, the next step clears the low byte and advances the high byte, so the high byte moves once every 32 steps. The wrap of the high byte from 8'hFF sets ovfFlag. After any step, low bits [7:5] read 0.
- R6: modeSel 3 (reload mode): the step after a low byte of 8'hFF loads the low byte with the high byte's value and sets ovfFlag. Counting never changes the high byte, so a new high-byte value takes effect only at the next reload.
- R7: ovfFlag stays set until a cycle in which ovfClr is high and no overflow occurs. If an overflow and ovfClr fall in the same cycle, the flag stays set.
- R8: With runEn low, neither count byte changes unless it is written.
- R9: A byte written with lowWrEn or highWrEn holds the written data from the next clock onward. The write takes priority over a step in the same cycle.
- R10: ovfPulse is high for exactly one clock for each overflow that sets ovfFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Counting enable |
| modeSel | input | 2 | 0 wide, 1 split, 2 prescaled, 3 reload |
| countSel | input | 1 | 0 machine cycles, 1 external edges |
| eventIn | input | 1 | External event pin (asynchronous) |
| lowWrEn | input | 1 | Write strobe for the low byte |
| lowWrData | input | 8 | Data for the low byte |
| highWrEn | input | 1 | Write strobe for the high byte |
| highWrData | input | 8 | Data for the high byte |
| ovfClr | input | 1 | Clear strobe for ovfFlag |
| auxClr | input | 1 | Clear strobe for auxFlag |
| lowCount | output | 8 | Low count byte |
| highCount | output | 8 | High count byte |
| ovfFlag | output | 1 | Sticky main overflow flag |
| auxFlag | output | 1 | Sticky split-mode high-byte overflow flag |
| ovfPulse | output | 1 | One-clock pulse on each main overflow |

## Verification
The assertions assume that modeSel and countSel stay fixed while counting is under way. They also assume that eventIn holds each level for longer than one machine cycle, so that the once-per-cycle sampler cannot miss an edge. The stimulus changes the mode only around writes that set a known starting value. It drives eventIn with high and low phases two machine cycles long. Because the bench cannot know the phase of the divider, every timed check waits a whole number of machine cycles after a write. The one check that needs the overflow and the clear in the same cycle first locks onto an observed overflow pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W     = 8;
  localparam int CYCLE_CLKS = 12;
  localparam int PRESCALE_W = 5;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'd0,
    MODE_SPLIT    = 2'd1,
    MODE_PRESCALE = 2'd2,
    MODE_RELOAD   = 2'd3
  } tmrMode_e;

  typedef struct packed {
    logic incMain;
    logic incAux;
    logic wrLow;
    logic wrHigh;
    logic clrMain;
    logic clrAux;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int CYCLE_CLKS  = tmr_pkg::CYCLE_CLKS,
  parameter int SYNC_STAGES = tmr_pkg::SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       countSel,
  input  logic       eventIn,
  input  logic       lowWrEn,
  input  logic       highWrEn,
  input  logic       ovfClr,
  input  logic       auxClr,
  output tmrStrobe_t stb
);
  localparam int CNT_W = (CYCLE_CLKS > 1) ? $clog2(CYCLE_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CYCLE_CLKS - 1);

  logic [CNT_W-1:0] cycCnt;
  logic             mcTick;
  logic [SYNC_STAGES-1:0] syncQ;
  logic             lastSample;
  logic             riseSeen;

  // machine-cycle timebase
  always_ff @(posedge clk) begin
    if (!rstN) cycCnt <= '0;
    else if (cycCnt == LAST_CNT) cycCnt <= '0;
    else cycCnt <= cycCnt + CNT_W'(1);
  end
  assign mcTick = (cycCnt == LAST_CNT);

  // synchronizer chain for the event pin
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else syncQ[gi] <= eventIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) syncQ[gi] <= 1'b0;
          else syncQ[gi] <= syncQ[gi-1];
        end
      end
    end
  endgenerate

  // once-per-machine-cycle sample of the synchronized level
  always_ff @(posedge clk) begin
    if (!rstN) lastSample <= 1'b0;
    else if (mcTick) lastSample <= syncQ[SYNC_STAGES-1];
  end
  assign riseSeen = mcTick && syncQ[SYNC_STAGES-1] && !lastSample;

  always_comb begin
    stb.incMain = runEn && (countSel ? riseSeen : mcTick);
    stb.incAux  = runEn && mcTick;
    stb.wrLow   = lowWrEn;
    stb.wrHigh  = highWrEn;
    stb.clrMain = ovfClr;
    stb.clrAux  = auxClr;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incAux |=> !stb.incAux);

  // R2
  edge_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countSel && stb.incMain) |=> (lastSample && !stb.incMain));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int BYTE_W     = tmr_pkg::BYTE_W,
  parameter int PRESCALE_W = tmr_pkg::PRESCALE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrMode_e          mode,
  input  tmrStrobe_t        stb,
  input  logic [BYTE_W-1:0] lowWrData,
  input  logic [BYTE_W-1:0] highWrData,
  output logic [BYTE_W-1:0] lowQ,
  output logic [BYTE_W-1:0] highQ,
  output logic              ovfFlag,
  output logic              auxFlag,
  output logic              ovfPulse
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam logic [BYTE_W-1:0]     BYTE_MAX = '1;
  localparam logic [PRESCALE_W-1:0] PRE_MAX  = '1;

  logic [BYTE_W-1:0] lowNext, highNext;
  logic              mainOvf, auxOvf;

  always_comb begin
    lowNext  = lowQ;
    highNext = highQ;
    mainOvf  = 1'b0;
    auxOvf   = 1'b0;
    unique case (mode)
      MODE_WIDE: begin
        if (stb.incMain) begin
          {highNext, lowNext} = {highQ, lowQ} + WIDE_W'(1);
          mainOvf = (lowQ == BYTE_MAX) && (highQ == BYTE_MAX);
        end
      end
      MODE_SPLIT: begin
        if (stb.incMain) begin
          lowNext = lowQ + BYTE_W'(1);
          mainOvf = (lowQ == BYTE_MAX);
        end
        if (stb.incAux) begin
          highNext = highQ + BYTE_W'(1);
          auxOvf   = (highQ == BYTE_MAX);
        end
      end
      MODE_PRESCALE: begin
        if (stb.incMain) begin
          lowNext = '0;
          if (lowQ[PRESCALE_W-1:0] == PRE_MAX) begin
            highNext = highQ + BYTE_W'(1);
            mainOvf  = (highQ == BYTE_MAX);
          end else begin
            lowNext[PRESCALE_W-1:0] = lowQ[PRESCALE_W-1:0] + PRESCALE_W'(1);
          end
        end
      end
      default: begin
        if (stb.incMain) begin
          if (lowQ == BYTE_MAX) begin
            lowNext = highQ;
            mainOvf = 1'b1;
          end else begin
            lowNext = lowQ + BYTE_W'(1);
          end
        end
      end
    endcase
    if (stb.wrLow)  lowNext  = lowWrData;
    if (stb.wrHigh) highNext = highWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ     <= '0;
      highQ    <= '0;
      ovfFlag  <= 1'b0;
      auxFlag  <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      lowQ     <= lowNext;
      highQ    <= highNext;
      ovfPulse <= mainOvf;
      if (mainOvf) ovfFlag <= 1'b1;
      else if (stb.clrMain) ovfFlag <= 1'b0;
      if (auxOvf) auxFlag <= 1'b1;
      else if (stb.clrAux) auxFlag <= 1'b0;
    end
  end

  // R3
  wide_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incMain && mode == MODE_WIDE && lowQ == BYTE_MAX && highQ == BYTE_MAX
     && !stb.wrLow && !stb.wrHigh) |=> (lowQ == '0 && highQ == '0 && ovfFlag));

  // R5
  prescale_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incMain && mode == MODE_PRESCALE && !stb.wrLow)
      |=> (lowQ[BYTE_W-1:PRESCALE_W] == '0));

  // R6
  reload_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incMain && mode == MODE_RELOAD && lowQ == BYTE_MAX && !stb.wrLow && !stb.wrHigh)
      |=> (lowQ == $past(highQ) && highQ == $past(highQ) && ovfFlag));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stb.clrMain) |=> ovfFlag);

  // R10
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> ovfFlag);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] modeSel,
  input  logic       countSel,
  input  logic       eventIn,
  input  logic       lowWrEn,
  input  logic [7:0] lowWrData,
  input  logic       highWrEn,
  input  logic [7:0] highWrData,
  input  logic       ovfClr,
  input  logic       auxClr,
  output logic [7:0] lowCount,
  output logic [7:0] highCount,
  output logic       ovfFlag,
  output logic       auxFlag,
  output logic       ovfPulse
);
  tmrStrobe_t stb;

  tmr_ctrl #(.CYCLE_CLKS(CYCLE_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .countSel(countSel),
    .eventIn(eventIn), .lowWrEn(lowWrEn), .highWrEn(highWrEn),
    .ovfClr(ovfClr), .auxClr(auxClr), .stb(stb)
  );

  tmr_datapath #(.BYTE_W(BYTE_W), .PRESCALE_W(PRESCALE_W)) u_data (
    .clk(clk), .rstN(rstN), .mode(tmrMode_e'(modeSel)), .stb(stb),
    .lowWrData(lowWrData), .highWrData(highWrData),
    .lowQ(lowCount), .highQ(highCount),
    .ovfFlag(ovfFlag), .auxFlag(auxFlag), .ovfPulse(ovfPulse)
  );

  // R8
  run_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !lowWrEn && !highWrEn) |=> ($stable(lowCount) && $stable(highCount)));

  // R9
  write_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowWrEn |=> (lowCount == $past(lowWrData)));
endmodule

// File: tb/tmr_unit_test.sv
`timescale 1ns/1ps
module tmr_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic countSel = 1'b0;
  logic eventIn = 1'b0;
  logic lowWrEn = 1'b0;
  logic [7:0] lowWrData = 8'd0;
  logic highWrEn = 1'b0;
  logic [7:0] highWrData = 8'd0;
  logic ovfClr = 1'b0;
  logic auxClr = 1'b0;
  logic [7:0] lowCount, highCount;
  logic ovfFlag, auxFlag, ovfPulse;

  always #4 clk = ~clk;

  tmr_unit uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel), .countSel(countSel),
    .eventIn(eventIn), .lowWrEn(lowWrEn), .lowWrData(lowWrData),
    .highWrEn(highWrEn), .highWrData(highWrData), .ovfClr(ovfClr), .auxClr(auxClr),
    .lowCount(lowCount), .highCount(highCount), .ovfFlag(ovfFlag),
    .auxFlag(auxFlag), .ovfPulse(ovfPulse)
  );

  typedef struct {
    string req;
    int    sel;
    int    exp;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  bit finished = 1'b0;

  always @(negedge clk) if (ovfPulse) pulseCnt++;

  function automatic int observe(int sel);
    case (sel)
      0: return int'(lowCount);
      1: return int'(highCount);
      2: return int'(ovfFlag);
      3: return int'(auxFlag);
      default: return pulseCnt;
    endcase
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        int act;
        it = sbq.pop_front();
        act = observe(it.sel);
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%0h expected=%0h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(input string req, input int sel, input int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrBytes(input bit doLo, input logic [7:0] lo, input bit doHi, input logic [7:0] hi);
    lowWrEn = doLo; lowWrData = lo;
    highWrEn = doHi; highWrData = hi;
    step(1);
    lowWrEn = 1'b0; highWrEn = 1'b0;
  endtask

  task automatic pulseClr(input bit mainSide);
    if (mainSide) ovfClr = 1'b1; else auxClr = 1'b1;
    step(1);
    ovfClr = 1'b0; auxClr = 1'b0;
  endtask

  task automatic summary;
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    int base;
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    expectVal("R1 reset low", 0, 0);
    expectVal("R1 reset high", 1, 0);
    expectVal("R1 reset flag", 2, 0);
    expectVal("R1 reset aux", 3, 0);

    runEn = 1'b1; modeSel = 2'd0; countSel = 1'b0;
    wrBytes(1, 8'h00, 1, 8'h00);
    step(12 * 5);
    expectVal("R1 five machine cycles", 0, 5);
    expectVal("R1 high untouched", 1, 0);

    // R9 write takes effect next clock
    wrBytes(1, 8'h42, 0, 8'h00);
    expectVal("R9 low write", 0, 8'h42);

    // R3 wide wrap
    wrBytes(1, 8'hFF, 1, 8'hFF);
    base = pulseCnt;
    step(12);
    expectVal("R3 wrap low", 0, 0);
    expectVal("R3 wrap high", 1, 0);
    expectVal("R3 flag set", 2, 1);
    expectVal("R10 one pulse", 4, base + 1);
    step(12 * 3);
    // R7 sticky
    expectVal("R7 flag sticky", 2, 1);
    expectVal("R10 still one pulse", 4, base + 1);
    pulseClr(1);
    expectVal("R7 flag cleared", 2, 0);

    // R8 freeze
    runEn = 1'b0;
    wrBytes(1, 8'h33, 1, 8'h44);
    step(120);
    expectVal("R8 low frozen", 0, 8'h33);
    expectVal("R8 high frozen", 1, 8'h44);
    runEn = 1'b1;

    // R2 counter mode
    countSel = 1'b1; eventIn = 1'b0;
    wrBytes(1, 8'h00, 1, 8'h00);
    step(48);
    for (int k = 0; k < 3; k++) begin
      eventIn = 1'b1; step(24);
      eventIn = 1'b0; step(24);
    end
    step(48);
    expectVal("R2 three edges", 0, 3);
    expectVal("R2 high quiet", 1, 0);
    eventIn = 1'b1;
    step(96);
    expectVal("R2 held level counts once", 0, 4);
    eventIn = 1'b0;
    step(48);

    // R4 split mode
    modeSel = 2'd1;
    wrBytes(1, 8'hFE, 1, 8'hFD);
    step(12 * 3);
    expectVal("R4 high counts cycles", 1, 0);
    expectVal("R4 aux flag", 3, 1);
    expectVal("R4 low no events", 0, 8'hFE);
    expectVal("R4 main flag clear", 2, 0);
    countSel = 1'b0;
    wrBytes(1, 8'hFF, 0, 8'h00);
    step(12);
    expectVal("R4 low wrap", 0, 0);
    expectVal("R4 main flag", 2, 1);
    pulseClr(0);
    expectVal("R4 aux cleared", 3, 0);
    pulseClr(1);

    // R5 prescaled
    modeSel = 2'd2;
    wrBytes(1, 8'h00, 1, 8'h00);
    step(12 * (32 * 2 + 5));
    expectVal("R5 high every 32", 1, 2);
    expectVal("R5 prescaler value", 0, 5);
    wrBytes(1, 8'hE0, 0, 8'h00);
    step(12);
    expectVal("R5 top bits cleared", 0, 8'h01);
    wrBytes(1, 8'h1F, 1, 8'hFF);
    step(12);
    expectVal("R5 wrap low", 0, 0);
    expectVal("R5 wrap high", 1, 0);
    expectVal("R5 flag", 2, 1);
    pulseClr(1);

    // R6 reload
    modeSel = 2'd3;
    wrBytes(1, 8'hFE, 1, 8'hF0);
    step(12);
    expectVal("R6 before terminal", 0, 8'hFF);
    step(12);
    expectVal("R6 reloaded", 0, 8'hF0);
    expectVal("R6 high kept", 1, 8'hF0);
    expectVal("R6 flag", 2, 1);
    wrBytes(0, 8'h00, 1, 8'h10);
    step(12);
    expectVal("R6 new reload not yet used", 0, 8'hF1);
    wrBytes(1, 8'hFF, 0, 8'h00);
    step(12);
    expectVal("R6 new reload used", 0, 8'h10);
    expectVal("R6 high still", 1, 8'h10);

    // R7 overflow and clear in the same cycle
    modeSel = 2'd1;
    wrBytes(1, 8'hFF, 0, 8'h00);
    for (int g = 0; g < 40 && !ovfPulse; g++) step(1);
    ovfClr = 1'b1; lowWrEn = 1'b1; lowWrData = 8'hFF;
    step(1);
    ovfClr = 1'b0; lowWrEn = 1'b0;
    expectVal("R7 cleared before test", 2, 0);
    step(10);
    ovfClr = 1'b1;
    step(1);
    ovfClr = 1'b0;
    expectVal("R7 set wins over clear", 2, 1);
    expectVal("R7 low wrapped", 0, 0);

    finished = 1'b1;
    summary();
  end
endmodule